// File: doc/BRIEF.md
# Circular Reorder Buffer with In-Order Commit

The block is a circular table of in-flight instruction entries. Decode places entries in program order through an allocate port, and each new entry gets the index of its slot as its tag. Source operands come either as ready values or as the tag of a producing entry. A result port carries a tag, a value and an exception cause. A result both completes its producing entry and fills every waiting source that names that tag. The block flags each entry whose operands are all present, whatever its age. An external selector picks one through the issue port and reads its operands there.

Retirement is strictly in program order from an oldest-entry pointer, at most one entry per cycle. An entry is retired only after its result has arrived. A clean entry is presented on the commit port with its destination, data and store flag, so stores reach memory only at this point. An entry with a nonzero cause is reported instead on the exception outputs for one cycle and is not written anywhere. In the same cycle the buffer empties: the allocate pointer takes the value of the oldest-entry pointer, and every younger entry is dropped.

Each pointer has one extra wrap bit, which tells a full buffer from an empty one. Allocation is refused while the buffer is full.

Top module: `ooo_reorder_buf`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, ready_mask is 0, and cmt_valid and exc_valid are 0.
- R2: Tags are handed out in allocation order, each one the previous tag plus one modulo DEPTH. After DEPTH allocations with no retirement, alloc_ready is 0, and an alloc_valid pulse in that state stores nothing.
- R3: A result with res_valid, whose res_tag matches a waiting source tag of an occupied entry, marks that source ready with res_data as its value. The value can then be read through the issue port.
- R4: An allocation in the same cycle as a result whose tag matches a not-ready source of that allocation stores the source as ready, with the result value.
- R5: ready_mask bit i is 1 exactly when entry i is occupied, has neither been issued nor completed, and has both sources ready. A younger entry can be flagged while an older one waits.
- R6: Driving iss_valid with iss_tag presents that entry's operation and operand values combinationally, and at the clock edge clears its ready_mask bit.
- R7: Only the oldest entry can retire, and only after its result has arrived. Results that arrive out of order still appear on the commit port one per cycle, in allocation order, with that entry's tag, destination and data.
- R8: cmt_store repeats the store flag given at allocation, and it is reported only in the cycle that entry commits.
- R9: When the oldest completed entry has a nonzero cause, exc_valid is 1 for one cycle with exc_tag and exc_cause, and cmt_valid stays 0 in that cycle.
- R10: A result whose tag names an unoccupied slot is ignored. A later allocation into that slot is not treated as complete.
- R11: After an exception the buffer is empty and its younger entries never commit. The next allocation receives the excepting entry's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_op | input | OP_W | Operation code |
| alloc_dest | input | REG_W | Destination register |
| alloc_store | input | 1 | Entry is a store |
| alloc_a_tag | input | TAG_W | Producer tag of source A |
| alloc_a_rdy | input | 1 | Source A value present |
| alloc_a_val | input | DATA_W | Source A value |
| alloc_b_tag | input | TAG_W | Producer tag of source B |
| alloc_b_rdy | input | 1 | Source B value present |
| alloc_b_val | input | DATA_W | Source B value |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_tag | output | TAG_W | Tag the next allocation receives |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the finishing entry |
| res_data | input | DATA_W | Result value |
| res_cause | input | CAUSE_W | Exception cause, 0 for none |
| iss_valid | input | 1 | Mark entry as issued |
| iss_tag | input | TAG_W | Entry being issued or read |
| iss_op | output | OP_W | Operation of entry iss_tag |
| iss_a | output | DATA_W | Source A value of entry iss_tag |
| iss_b | output | DATA_W | Source B value of entry iss_tag |
| ready_mask | output | DEPTH | Entries ready for issue |
| cmt_valid | output | 1 | Oldest entry commits this cycle |
| cmt_tag | output | TAG_W | Tag of committing entry |
| cmt_dest | output | REG_W | Destination of committing entry |
| cmt_data | output | DATA_W | Data of committing entry |
| cmt_store | output | 1 | Committing entry is a store |
| exc_valid | output | 1 | Oldest entry raised an exception |
| exc_tag | output | TAG_W | Tag of excepting entry |
| exc_cause | output | CAUSE_W | Cause of excepting entry |

## Verification
The properties assume the environment sends at most one result per occupied entry. They also assume it never issues an entry twice and never names a tag as a source unless that entry is still in flight or the value is marked ready. The directed tasks keep within this. Each result is sent once, after the entry's allocation. Sources use either ready values or tags of live entries. The only broadcast to a free slot is the one made deliberately for R10, at a time when no waiting source names that slot.

// File: rtl/ooo_reorder_buf.sv
module ooo_reorder_buf #(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int OP_W    = 4,
  parameter int CAUSE_W = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [REG_W-1:0]   alloc_dest,
  input  logic               alloc_store,
  input  logic [TAG_W-1:0]   alloc_a_tag,
  input  logic               alloc_a_rdy,
  input  logic [DATA_W-1:0]  alloc_a_val,
  input  logic [TAG_W-1:0]   alloc_b_tag,
  input  logic               alloc_b_rdy,
  input  logic [DATA_W-1:0]  alloc_b_val,
  output logic               alloc_ready,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  input  logic [DATA_W-1:0]  res_data,
  input  logic [CAUSE_W-1:0] res_cause,
  input  logic               iss_valid,
  input  logic [TAG_W-1:0]   iss_tag,
  output logic [OP_W-1:0]    iss_op,
  output logic [DATA_W-1:0]  iss_a,
  output logic [DATA_W-1:0]  iss_b,
  output logic [DEPTH-1:0]   ready_mask,
  output logic               cmt_valid,
  output logic [TAG_W-1:0]   cmt_tag,
  output logic [REG_W-1:0]   cmt_dest,
  output logic [DATA_W-1:0]  cmt_data,
  output logic               cmt_store,
  output logic               exc_valid,
  output logic [TAG_W-1:0]   exc_tag,
  output logic [CAUSE_W-1:0] exc_cause
);

  logic [PTR_W-1:0]   alloc_ptr, cmt_ptr;
  logic [DEPTH-1:0]   used_q, exec_q, done_q, store_q, a_rdy_q, b_rdy_q;
  logic [OP_W-1:0]    op_q    [DEPTH];
  logic [REG_W-1:0]   dest_q  [DEPTH];
  logic [TAG_W-1:0]   a_tag_q [DEPTH];
  logic [TAG_W-1:0]   b_tag_q [DEPTH];
  logic [DATA_W-1:0]  a_val_q [DEPTH];
  logic [DATA_W-1:0]  b_val_q [DEPTH];
  logic [DATA_W-1:0]  res_q   [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];

  logic [TAG_W-1:0] head, tail;
  logic full, head_fin, head_bad, alloc_fire, a_hit, b_hit;

  assign head = cmt_ptr[TAG_W-1:0];
  assign tail = alloc_ptr[TAG_W-1:0];
  assign full = (alloc_ptr[TAG_W] != cmt_ptr[TAG_W]) && (tail == head);

  assign head_fin = used_q[head] & done_q[head];
  assign head_bad = cause_q[head] != '0;

  assign cmt_valid = head_fin & ~head_bad;
  assign exc_valid = head_fin & head_bad;
  assign cmt_tag   = head;
  assign exc_tag   = head;
  assign cmt_dest  = dest_q[head];
  assign cmt_data  = res_q[head];
  assign cmt_store = store_q[head] & cmt_valid;
  assign exc_cause = exc_valid ? cause_q[head] : '0;

  assign alloc_ready = ~full & ~exc_valid;
  assign alloc_tag   = tail;
  assign alloc_fire  = alloc_valid & alloc_ready;

  assign a_hit = res_valid && !alloc_a_rdy && (res_tag == alloc_a_tag);
  assign b_hit = res_valid && !alloc_b_rdy && (res_tag == alloc_b_tag);

  assign iss_op = op_q[iss_tag];
  assign iss_a  = a_val_q[iss_tag];
  assign iss_b  = b_val_q[iss_tag];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rdy
    assign ready_mask[g] = used_q[g] & ~exec_q[g] & ~done_q[g] & a_rdy_q[g] & b_rdy_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ptr <= '0;
      cmt_ptr   <= '0;
      used_q    <= '0;
      exec_q    <= '0;
      done_q    <= '0;
      store_q   <= '0;
      a_rdy_q   <= '0;
      b_rdy_q   <= '0;
    end else if (exc_valid) begin
      used_q    <= '0;
      alloc_ptr <= cmt_ptr;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (used_q[i] && res_valid) begin
          if (!a_rdy_q[i] && a_tag_q[i] == res_tag) begin
            a_rdy_q[i] <= 1'b1;
            a_val_q[i] <= res_data;
          end
          if (!b_rdy_q[i] && b_tag_q[i] == res_tag) begin
            b_rdy_q[i] <= 1'b1;
            b_val_q[i] <= res_data;
          end
          if (res_tag == TAG_W'(i)) begin
            done_q[i]  <= 1'b1;
            res_q[i]   <= res_data;
            cause_q[i] <= res_cause;
          end
        end
      end
      if (iss_valid && used_q[iss_tag])
        exec_q[iss_tag] <= 1'b1;
      if (cmt_valid) begin
        used_q[head] <= 1'b0;
        cmt_ptr      <= cmt_ptr + 1'b1;
      end
      if (alloc_fire) begin
        used_q[tail]  <= 1'b1;
        exec_q[tail]  <= 1'b0;
        done_q[tail]  <= 1'b0;
        store_q[tail] <= alloc_store;
        op_q[tail]    <= alloc_op;
        dest_q[tail]  <= alloc_dest;
        cause_q[tail] <= '0;
        a_tag_q[tail] <= alloc_a_tag;
        b_tag_q[tail] <= alloc_b_tag;
        a_rdy_q[tail] <= alloc_a_rdy | a_hit;
        b_rdy_q[tail] <= alloc_b_rdy | b_hit;
        a_val_q[tail] <= a_hit ? res_data : alloc_a_val;
        b_val_q[tail] <= b_hit ? res_data : alloc_b_val;
        alloc_ptr     <= alloc_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ooo_reorder_buf_chk.sv
module ooo_reorder_buf_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] cmt_tag,
  input logic             exc_valid,
  input logic [TAG_W-1:0] exc_tag
);

  logic [TAG_W:0]   occ;
  logic [TAG_W-1:0] exp_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ      <= '0;
      exp_head <= '0;
    end else if (exc_valid) begin
      occ <= '0;
    end else begin
      occ <= occ + (TAG_W+1)'(alloc_valid && alloc_ready) - (TAG_W+1)'(cmt_valid);
      if (cmt_valid) exp_head <= exp_head + 1'b1;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_refuse_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) == DEPTH) |-> !alloc_ready);

  assert_tag_sequence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1));

  assert_commit_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> cmt_tag == exp_head);

  assert_exc_at_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_tag == exp_head && !cmt_valid));

  assert_exc_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (alloc_ready && alloc_tag == $past(exc_tag) && !cmt_valid));

endmodule

bind ooo_reorder_buf ooo_reorder_buf_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
  .exc_valid(exc_valid), .exc_tag(exc_tag)
);

// File: tb/ooo_reorder_buf_tb.sv
module ooo_reorder_buf_tb;
  localparam int DEPTH = 8, DATA_W = 32, REG_W = 5, OP_W = 4, CAUSE_W = 4, TAG_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_store = 0, alloc_a_rdy = 0, alloc_b_rdy = 0;
  logic [OP_W-1:0] alloc_op = '0;
  logic [REG_W-1:0] alloc_dest = '0;
  logic [TAG_W-1:0] alloc_a_tag = '0, alloc_b_tag = '0;
  logic [DATA_W-1:0] alloc_a_val = '0, alloc_b_val = '0;
  logic alloc_ready;
  logic [TAG_W-1:0] alloc_tag;
  logic res_valid = 0;
  logic [TAG_W-1:0] res_tag = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic [CAUSE_W-1:0] res_cause = '0;
  logic iss_valid = 0;
  logic [TAG_W-1:0] iss_tag = '0;
  logic [OP_W-1:0] iss_op;
  logic [DATA_W-1:0] iss_a, iss_b, cmt_data;
  logic [DEPTH-1:0] ready_mask;
  logic cmt_valid, cmt_store, exc_valid;
  logic [TAG_W-1:0] cmt_tag, exc_tag;
  logic [REG_W-1:0] cmt_dest;
  logic [CAUSE_W-1:0] exc_cause;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ooo_reorder_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dest(alloc_dest),
    .alloc_store(alloc_store), .alloc_a_tag(alloc_a_tag), .alloc_a_rdy(alloc_a_rdy),
    .alloc_a_val(alloc_a_val), .alloc_b_tag(alloc_b_tag), .alloc_b_rdy(alloc_b_rdy),
    .alloc_b_val(alloc_b_val), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .res_cause(res_cause),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .ready_mask(ready_mask), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dest(cmt_dest),
    .cmt_data(cmt_data), .cmt_store(cmt_store), .exc_valid(exc_valid), .exc_tag(exc_tag),
    .exc_cause(exc_cause)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    alloc_valid = 0; res_valid = 0; iss_valid = 0; res_cause = '0;
    #1;
  endtask

  task automatic do_alloc(input logic [OP_W-1:0] op, input logic [REG_W-1:0] dst, input logic st,
                          input logic [TAG_W-1:0] at, input logic ar, input logic [DATA_W-1:0] av,
                          input logic [TAG_W-1:0] bt, input logic br, input logic [DATA_W-1:0] bv,
                          output logic [TAG_W-1:0] tag);
    alloc_valid = 1; alloc_op = op; alloc_dest = dst; alloc_store = st;
    alloc_a_tag = at; alloc_a_rdy = ar; alloc_a_val = av;
    alloc_b_tag = bt; alloc_b_rdy = br; alloc_b_val = bv;
    #1;
    tag = alloc_tag;
    check("R2 alloc_ready", alloc_ready, 1);
    step();
  endtask

  task automatic send(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d, input logic [CAUSE_W-1:0] c);
    res_valid = 1; res_tag = t; res_data = d; res_cause = c;
    step();
  endtask

  task automatic expect_commit(string req, logic [TAG_W-1:0] t, logic [REG_W-1:0] dst,
                               logic [DATA_W-1:0] d, logic st);
    check({req, " cmt_valid"}, cmt_valid, 1);
    check({req, " cmt_tag"}, cmt_tag, t);
    check({req, " cmt_dest"}, cmt_dest, dst);
    check({req, " cmt_data"}, cmt_data, d);
    check({req, " cmt_store"}, cmt_store, st);
    step();
  endtask

  task automatic t_reset();
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 ready_mask", ready_mask, 0);
    check("R1 cmt_valid", cmt_valid, 0);
    check("R1 exc_valid", exc_valid, 0);
  endtask

  task automatic t_ooo_complete();
    logic [TAG_W-1:0] ta, tb, tc;
    do_alloc(4'd1, 5'd1, 0, 0, 1, 10, 0, 1, 20, ta);
    do_alloc(4'd2, 5'd2, 0, 0, 1, 5, ta, 0, 0, tb);
    do_alloc(4'd3, 5'd3, 1, 0, 1, 7, 0, 1, 8, tc);
    check("R2 tag a", ta, 0);
    check("R2 tag b", tb, 1);
    check("R2 tag c", tc, 2);
    check("R5 younger flagged", ready_mask, 8'b0000_0101);
    iss_valid = 1; iss_tag = tc; #1;
    check("R6 iss_op", iss_op, 3);
    check("R6 iss_a", iss_a, 7);
    check("R6 iss_b", iss_b, 8);
    step();
    check("R6 mask after issue", ready_mask, 8'b0000_0001);
    send(tc, 100, 0);
    check("R7 head not done", cmt_valid, 0);
    iss_valid = 1; iss_tag = ta; step();
    send(ta, 30, 0);
    check("R3 wakeup mask", ready_mask, 8'b0000_0010);
    iss_valid = 1; iss_tag = tb; #1;
    check("R3 woken value", iss_b, 30);
    check("R3 kept value", iss_a, 5);
    expect_commit("R7 first", ta, 1, 30, 0);
    check("R7 waits on b", cmt_valid, 0);
    send(tb, 77, 0);
    expect_commit("R7 second", tb, 2, 77, 0);
    expect_commit("R8 store", tc, 3, 100, 1);
    check("R7 drained", cmt_valid, 0);
    check("R8 no stray store", cmt_store, 0);
  endtask

  task automatic t_bypass();
    logic [TAG_W-1:0] td, te;
    do_alloc(4'd4, 5'd4, 0, 0, 1, 1, 0, 1, 2, td);
    res_valid = 1; res_tag = td; res_data = 55; res_cause = '0;
    do_alloc(4'd5, 5'd5, 0, td, 0, 0, 0, 1, 1, te);
    check("R4 ready after bypass", ready_mask, 8'b0001_0000);
    iss_tag = te; #1;
    check("R4 captured value", iss_a, 55);
    expect_commit("R4 producer", td, 4, 55, 0);
    send(te, 9, 0);
    expect_commit("R4 consumer", te, 5, 9, 0);
  endtask

  task automatic t_unused_tag();
    logic [TAG_W-1:0] tf, tg;
    send(3'd6, 123, 0);
    do_alloc(4'd6, 5'd6, 0, 0, 1, 0, 0, 1, 0, tf);
    do_alloc(4'd7, 5'd7, 0, 0, 1, 0, 0, 1, 0, tg);
    check("R10 tag f", tf, 5);
    check("R10 tag g", tg, 6);
    send(tf, 1, 0);
    expect_commit("R10 f", tf, 6, 1, 0);
    check("R10 stale result ignored", cmt_valid, 0);
    send(tg, 2, 0);
    expect_commit("R10 g", tg, 7, 2, 0);
  endtask

  task automatic t_full_and_flush();
    logic [TAG_W-1:0] t, head;
    head = alloc_tag;
    for (int k = 0; k < DEPTH; k++) begin
      do_alloc(4'd8, 5'd9, 1, 0, 1, 0, 0, 1, 0, t);
      check("R2 wrap tag", t, TAG_W'(head + k));
    end
    check("R2 full refuses", alloc_ready, 0);
    alloc_valid = 1; alloc_op = 4'd15; step();
    check("R2 refused alloc stores nothing", ready_mask, 8'hFF);
    send(TAG_W'(head + 1), 5, 0);
    check("R7 younger done not committed", cmt_valid, 0);
    res_valid = 1; res_tag = head; res_data = 0; res_cause = 4'd3;
    step();
    check("R9 exc_valid", exc_valid, 1);
    check("R9 exc_cause", exc_cause, 3);
    check("R9 exc_tag", exc_tag, head);
    check("R9 no commit", cmt_valid, 0);
    step();
    check("R9 single pulse", exc_valid, 0);
    check("R11 no younger commit", cmt_valid, 0);
    check("R11 alloc_ready", alloc_ready, 1);
    check("R11 alloc_tag", alloc_tag, head);
    check("R11 mask cleared", ready_mask, 0);
    do_alloc(4'd2, 5'd11, 0, 0, 1, 0, 0, 1, 0, t);
    check("R11 reuse tag", t, head);
    send(t, 42, 0);
    expect_commit("R11 after flush", head, 11, 42, 0);
    check("R11 empty again", cmt_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    t_reset();
    t_ooo_complete();
    t_bypass();
    t_unused_tag();
    t_full_and_flush();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule